// File: doc/BRIEF.md
# Translation Unit Enable/Quiesce Controller

This block holds the single 32-bit control word of an interrupt translation unit and runs the sequencing around it. Software writes the word to turn the unit on or off, to enable an interrupt for unmapped incoming messages, to set a unit number and to set one implementation-specific bit. The block gates incoming translation requests and command-queue fetches on the effective enable state. It also reports a read-only quiescent flag that tells software when the unit has fully drained and can be powered down.

Quiescent is not a stored bit. It is derived from two saturating occupancy counters and a sync-pending input. One counter tracks transactions in flight. The other tracks operations forwarded downstream that have not yet been acknowledged. After an enable write, the enable takes effect only after a fixed settling period, and quiescent keeps reading 1 until then. Writes that could disturb an active unit are filtered in the register itself.

Top module: `xu_quiesce_ctrl`

## Requirements
- R1: In the control word, bit 31 is quiescent (read-only), bit 8 is the unmapped-message interrupt enable, bits [7:4] are the unit number, bit 1 is an implementation bit and bit 0 is enable. All other bits read 0, writes to them have no effect, and a write to bit 31 is ignored.
- R2: While the effective enable is off, a valid translation request is accepted (`xl_req_ready`=1) and dropped (`xl_fwd_valid`=0), and `cmd_fetch_grant` stays 0.
- R3: While the effective enable is on, `xl_fwd_valid` follows `xl_req_valid`, `xl_req_ready` follows `xl_eng_ready`, and `cmd_fetch_grant` follows `cmd_fetch_req`.
- R4: The effective enable (gating) turns on EN_SETTLE clock edges after the edge that writes enable=1 (default 3). Quiescent reads 1 until that edge and reads 0 from the following edge on. Clearing enable stops gating from the write edge.
- R5: With enable 0, quiescent reads 1 one edge after both counters are zero and `sync_pending` is 0. Otherwise it reads 0.
- R6: Quiescent stays 0 while any forwarded operation (`fwd_issue` pulses) lacks a matching `fwd_ack` pulse, even when no transaction is in flight.
- R7: `unmapped_irq` is registered. It is 1 one edge after a cycle in which `unmapped_status` is 1 and the interrupt-enable bit reads 1.
- R8: When `cap_irq_support` is 0, bit 8 reads 0 and `unmapped_irq` stays 0.
- R9: A write to the unit number takes effect only while enable is 0 and quiescent is 1. Otherwise the field keeps its value.
- R10: A write that sets enable from 0 to 1 while quiescent is 0 is ignored, and enable stays 0.
- R11: After reset the control word reads 0x8000_0000, `unmapped_irq` is 0, and no request is forwarded or fetch granted.
- R12: Bit 1 is an ordinary read/write bit when the parameter IMPL_BIT_RW is 1 (the default).
- R13: The occupancy counters do not wrap. A decrement pulse at zero leaves the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word value |
| cap_irq_support | input | 1 | Capability: unmapped-message interrupt supported |
| xl_req_valid | input | 1 | Incoming translation request valid |
| xl_req_ready | output | 1 | Translation request accepted |
| xl_fwd_valid | output | 1 | Request forwarded to the translation engine |
| xl_eng_ready | input | 1 | Translation engine ready |
| cmd_fetch_req | input | 1 | Command queue wants to fetch an entry |
| cmd_fetch_grant | output | 1 | Fetch allowed |
| txn_start | input | 1 | Pulse: a transaction entered flight |
| txn_done | input | 1 | Pulse: a transaction completed |
| fwd_issue | input | 1 | Pulse: an operation was forwarded downstream |
| fwd_ack | input | 1 | Pulse: a downstream acknowledgement arrived |
| sync_pending | input | 1 | Memory-consistency work outstanding |
| unmapped_status | input | 1 | Unmapped-message status flag |
| unmapped_irq | output | 1 | Unmapped-message interrupt |

## Verification
The assertions check several rules on every cycle: reserved bits read zero, nothing passes the gate while enable reads 0, the interrupt follows status and its enable one cycle later, the unit number and a blocked enable cannot change while the unit is active or undrained, and a busy unit never reports quiescent on the next cycle. Some behaviour only the bench scenarios can show. This covers the exact settling delay after enable, the drain sequence through the transaction, acknowledgement and sync conditions in turn, counter saturation at zero, and the capability mask on the interrupt enable.

// File: rtl/xu_ctrl_pkg.sv
// Package: field positions and masks of the translation unit control word.
// Assumes a single 32-bit word; positions other than those below are reserved.
package xu_ctrl_pkg;
    localparam int REG_W         = 32;
    localparam int POS_ENABLE    = 0;
    localparam int POS_IMPL      = 1;
    localparam int UNIT_LSB      = 4;
    localparam int UNIT_W        = 4;
    localparam int UNIT_MSB      = UNIT_LSB + UNIT_W - 1;
    localparam int POS_IRQ_EN    = 8;
    localparam int POS_QUIESCENT = 31;
    localparam logic [REG_W-1:0] RESERVED_MASK = 32'h7FFF_FE0C;
endpackage

// File: rtl/xu_ctrl_regs.sv
// Module: control word storage with write guards.
// Assumes `quiescent` is the registered drain flag; the unit number opens only
// when disabled and quiescent, and a 0->1 enable needs quiescent.
module xu_ctrl_regs
    import xu_ctrl_pkg::*;
#(
    parameter bit IMPL_BIT_RW = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             cap_irq,
    input  logic             quiescent,
    output logic             en_bit,
    output logic             irq_en,
    output logic [REG_W-1:0] rdata
);
    logic              en_q;
    logic              irq_q;
    logic              impl_q;
    logic [UNIT_W-1:0] unit_q;
    logic              unit_open;
    logic              unused_wbits;

    assign unit_open    = !en_q && quiescent;
    assign unused_wbits = ^{wdata[REG_W-1:POS_IRQ_EN+1], wdata[UNIT_LSB-1:POS_IMPL+1]};

    // Store the guarded fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            irq_q  <= 1'b0;
            unit_q <= '0;
        end else if (wr_en) begin
            en_q  <= wdata[POS_ENABLE] & (en_q | quiescent);
            irq_q <= wdata[POS_IRQ_EN] & cap_irq;
            if (unit_open) begin
                unit_q <= wdata[UNIT_MSB:UNIT_LSB];
            end
        end
    end

    generate
        if (IMPL_BIT_RW) begin : g_impl_rw
            // Plain read/write implementation bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    impl_q <= 1'b0;
                end else if (wr_en) begin
                    impl_q <= wdata[POS_IMPL];
                end
            end
        end else begin : g_impl_ro
            assign impl_q = 1'b0;
        end
    endgenerate

    assign en_bit = en_q;
    assign irq_en = irq_q & cap_irq;

    // Assemble the read view.
    always_comb begin
        rdata                      = '0;
        rdata[POS_QUIESCENT]       = quiescent;
        rdata[POS_IRQ_EN]          = irq_en;
        rdata[UNIT_MSB:UNIT_LSB]   = unit_q;
        rdata[POS_IMPL]            = impl_q;
        rdata[POS_ENABLE]          = en_q;
    end
endmodule

// File: rtl/xu_occupancy_cnt.sv
// Module: saturating up/down occupancy counter.
// Assumes one increment and one decrement pulse at most per cycle.
module xu_occupancy_cnt #(
    parameter int CNT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic empty
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Count up and down without wrapping at either end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10: if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                2'b01: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign empty = (cnt_q == '0);
endmodule

// File: rtl/xu_enable_seq.sv
// Module: enable settling and registered quiescent flag.
// Assumes EN_SETTLE >= 1; `drained` is true when no work is outstanding.
module xu_enable_seq #(
    parameter int EN_SETTLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_bit,
    input  logic drained,
    output logic en_active,
    output logic quiescent
);
    localparam int SW = (EN_SETTLE > 1) ? $clog2(EN_SETTLE) : 1;
    localparam logic [SW-1:0] LAST = SW'(EN_SETTLE - 1);

    logic [SW-1:0] settle_q;
    logic          active_q;
    logic          quiet_q;

    // Count settling cycles after enable before declaring it active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
            active_q <= 1'b0;
        end else if (!en_bit) begin
            settle_q <= '0;
            active_q <= 1'b0;
        end else if (!active_q) begin
            if (settle_q == LAST) begin
                active_q <= 1'b1;
            end else begin
                settle_q <= settle_q + 1'b1;
            end
        end
    end

    // Register the quiescent flag from the drain state or the enable phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= 1'b1;
        end else begin
            quiet_q <= en_bit ? !active_q : drained;
        end
    end

    assign en_active = active_q;
    assign quiescent = quiet_q;
endmodule

// File: rtl/xu_traffic_gate.sv
// Module: gates translation requests and command fetches on the enable.
// Assumes a disabled unit must still accept and drop requests.
module xu_traffic_gate (
    input  logic gate_on,
    input  logic xl_req_valid,
    input  logic xl_eng_ready,
    input  logic cmd_fetch_req,
    output logic xl_req_ready,
    output logic xl_fwd_valid,
    output logic cmd_fetch_grant
);
    // Pass or swallow traffic depending on the gate.
    always_comb begin
        xl_fwd_valid    = gate_on & xl_req_valid;
        xl_req_ready    = gate_on ? xl_eng_ready : 1'b1;
        cmd_fetch_grant = gate_on & cmd_fetch_req;
    end
endmodule

// File: rtl/xu_quiesce_ctrl.sv
// Module: top of the translation unit enable/quiesce controller.
// Assumes pulse inputs are one cycle wide and synchronous to clk.
module xu_quiesce_ctrl
    import xu_ctrl_pkg::*;
#(
    parameter int EN_SETTLE   = 3,
    parameter int CNT_W       = 6,
    parameter bit IMPL_BIT_RW = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cap_irq_support,
    input  logic             xl_req_valid,
    output logic             xl_req_ready,
    output logic             xl_fwd_valid,
    input  logic             xl_eng_ready,
    input  logic             cmd_fetch_req,
    output logic             cmd_fetch_grant,
    input  logic             txn_start,
    input  logic             txn_done,
    input  logic             fwd_issue,
    input  logic             fwd_ack,
    input  logic             sync_pending,
    input  logic             unmapped_status,
    output logic             unmapped_irq
);
    localparam int N_CNT = 2;

    logic             en_bit;
    logic             irq_en;
    logic             en_active;
    logic             quiescent;
    logic             drained;
    logic             all_empty;
    logic [N_CNT-1:0] cnt_inc;
    logic [N_CNT-1:0] cnt_dec;
    logic [N_CNT-1:0] cnt_empty;
    logic             irq_q;

    assign cnt_inc   = {fwd_issue, txn_start};
    assign cnt_dec   = {fwd_ack, txn_done};
    assign all_empty = &cnt_empty;
    assign drained   = all_empty && !sync_pending;

    xu_ctrl_regs #(.IMPL_BIT_RW(IMPL_BIT_RW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wdata     (reg_wdata),
        .cap_irq   (cap_irq_support),
        .quiescent (quiescent),
        .en_bit    (en_bit),
        .irq_en    (irq_en),
        .rdata     (reg_rdata)
    );

    generate
        for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
            xu_occupancy_cnt #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (cnt_inc[i]),
                .dec   (cnt_dec[i]),
                .empty (cnt_empty[i])
            );
        end
    endgenerate

    xu_enable_seq #(.EN_SETTLE(EN_SETTLE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_bit    (en_bit),
        .drained   (drained),
        .en_active (en_active),
        .quiescent (quiescent)
    );

    xu_traffic_gate u_gate (
        .gate_on         (en_active & en_bit),
        .xl_req_valid    (xl_req_valid),
        .xl_eng_ready    (xl_eng_ready),
        .cmd_fetch_req   (cmd_fetch_req),
        .xl_req_ready    (xl_req_ready),
        .xl_fwd_valid    (xl_fwd_valid),
        .cmd_fetch_grant (cmd_fetch_grant)
    );

    // Register the unmapped-message interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_en & unmapped_status;
        end
    end

    assign unmapped_irq = irq_q;
endmodule

// File: rtl/xu_quiesce_ctrl_chk.sv
// Module: assertion checker bound to xu_quiesce_ctrl.
// Assumes it observes the top's ports and its all_empty drain signal.
module xu_quiesce_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        cap_irq_support,
    input logic        xl_fwd_valid,
    input logic        cmd_fetch_grant,
    input logic        unmapped_status,
    input logic        unmapped_irq,
    input logic        all_empty,
    input logic        sync_pending
);
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 32'h7FFF_FE0C) == 32'h0);

    assert_gate_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |-> (!xl_fwd_valid && !cmd_fetch_grant));

    assert_busy_not_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[0] && (!all_empty || sync_pending)) |=> !reg_rdata[31]);

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_irq |-> $past(unmapped_status && reg_rdata[8]));

    assert_cap_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_irq_support |-> !reg_rdata[8]);

    assert_unit_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] || !reg_rdata[31]) |=> $stable(reg_rdata[7:4]));

    assert_enable_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[0] && !reg_rdata[31]) |=> !reg_rdata[0]);
endmodule

bind xu_quiesce_ctrl xu_quiesce_ctrl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_rdata       (reg_rdata),
    .cap_irq_support (cap_irq_support),
    .xl_fwd_valid    (xl_fwd_valid),
    .cmd_fetch_grant (cmd_fetch_grant),
    .unmapped_status (unmapped_status),
    .unmapped_irq    (unmapped_irq),
    .all_empty       (all_empty),
    .sync_pending    (sync_pending)
);

// File: tb/xu_quiesce_ctrl_tb.sv
module xu_quiesce_ctrl_tb;
    localparam int SETTLE = 3;
    localparam int NVEC   = 7;
    // {write data, expected read-back} while disabled and quiescent (R1, R9, R12)
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_0000, 32'h8000_0000},
        {32'h0000_0100, 32'h8000_0100},
        {32'h0000_00F0, 32'h8000_00F0},
        {32'h0000_0002, 32'h8000_0002},
        {32'h7FFF_FEFC, 32'h8000_00F0},
        {32'hFFFF_FF5E, 32'h8000_0152},
        {32'h0000_0A32, 32'h8000_0032}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_irq_support = 1'b1;
    logic        xl_req_valid = 1'b0;
    logic        xl_req_ready;
    logic        xl_fwd_valid;
    logic        xl_eng_ready = 1'b0;
    logic        cmd_fetch_req = 1'b0;
    logic        cmd_fetch_grant;
    logic        txn_start = 1'b0;
    logic        txn_done = 1'b0;
    logic        fwd_issue = 1'b0;
    logic        fwd_ack = 1'b0;
    logic        sync_pending = 1'b0;
    logic        unmapped_status = 1'b0;
    logic        unmapped_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    xu_quiesce_ctrl #(.EN_SETTLE(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cap_irq_support(cap_irq_support),
        .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready),
        .xl_fwd_valid(xl_fwd_valid), .xl_eng_ready(xl_eng_ready),
        .cmd_fetch_req(cmd_fetch_req), .cmd_fetch_grant(cmd_fetch_grant),
        .txn_start(txn_start), .txn_done(txn_done), .fwd_issue(fwd_issue),
        .fwd_ack(fwd_ack), .sync_pending(sync_pending),
        .unmapped_status(unmapped_status), .unmapped_irq(unmapped_irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(logic [31:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        tick();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11: reset state
        check("R11 rdata", reg_rdata, 32'h8000_0000);
        check("R11 irq", {31'b0, unmapped_irq}, 32'h0);
        cmd_fetch_req = 1'b1;
        xl_req_valid = 1'b1;
        #1;
        check("R11 fwd", {31'b0, xl_fwd_valid}, 32'h0);
        // R2: disabled gate accepts and drops, no fetch
        check("R2 ready", {31'b0, xl_req_ready}, 32'h1);
        check("R2 grant", {31'b0, cmd_fetch_grant}, 32'h0);

        // Vector table: R1, R9, R12
        for (int i = 0; i < NVEC; i++) begin
            reg_write(VEC[i][63:32]);
            check($sformatf("R1/R9/R12 vec%0d", i), reg_rdata, VEC[i][31:0]);
        end

        // R4: enable settling
        reg_write(32'h0000_0033);
        check("R4 rdata after write", reg_rdata, 32'h8000_0033);
        for (int k = 1; k < SETTLE; k++) begin
            check($sformatf("R4 grant pending %0d", k), {31'b0, cmd_fetch_grant}, 32'h0);
            tick();
        end
        check("R4 grant pending last", {31'b0, cmd_fetch_grant}, 32'h0);
        tick();
        check("R4 grant active", {31'b0, cmd_fetch_grant}, 32'h1);
        check("R4 quiescent still 1", {31'b0, reg_rdata[31]}, 32'h1);
        tick();
        check("R4 quiescent falls", reg_rdata, 32'h0000_0033);

        // R3: enabled forwarding
        xl_eng_ready = 1'b0;
        #1;
        check("R3 fwd", {31'b0, xl_fwd_valid}, 32'h1);
        check("R3 ready low", {31'b0, xl_req_ready}, 32'h0);
        xl_eng_ready = 1'b1;
        #1;
        check("R3 ready high", {31'b0, xl_req_ready}, 32'h1);

        // R9: unit number locked while enabled
        reg_write(32'h0000_00A1);
        check("R9 unit locked", reg_rdata, 32'h0000_0031);

        // R7: interrupt
        reg_write(32'h0000_0131);
        check("R7 rdata", reg_rdata, 32'h0000_0131);
        unmapped_status = 1'b1;
        #1;
        check("R7 irq not yet", {31'b0, unmapped_irq}, 32'h0);
        tick();
        check("R7 irq asserted", {31'b0, unmapped_irq}, 32'h1);
        unmapped_status = 1'b0;
        tick();
        check("R7 irq released", {31'b0, unmapped_irq}, 32'h0);

        // Drain sequence: R5, R6, R10
        txn_start = 1'b1;
        fwd_issue = 1'b1;
        tick();
        txn_start = 1'b0;
        fwd_issue = 1'b0;
        sync_pending = 1'b1;
        reg_write(32'h0000_0130);
        check("R5 disabled busy", reg_rdata, 32'h0000_0130);
        check("R2 fwd after disable", {31'b0, xl_fwd_valid}, 32'h0);
        tick();
        check("R5 still busy", {31'b0, reg_rdata[31]}, 32'h0);
        reg_write(32'h0000_0171);
        check("R10 enable blocked", reg_rdata, 32'h0000_0130);
        txn_done = 1'b1;
        tick();
        txn_done = 1'b0;
        tick();
        check("R6 unacked forward", {31'b0, reg_rdata[31]}, 32'h0);
        fwd_ack = 1'b1;
        tick();
        fwd_ack = 1'b0;
        tick();
        check("R5 sync pending", {31'b0, reg_rdata[31]}, 32'h0);
        sync_pending = 1'b0;
        tick();
        check("R5 drained", reg_rdata, 32'h8000_0130);

        // R13: decrement at zero does not wrap
        txn_done = 1'b1;
        tick();
        txn_done = 1'b0;
        tick();
        check("R13 stray done", {31'b0, reg_rdata[31]}, 32'h1);
        txn_start = 1'b1;
        tick();
        txn_start = 1'b0;
        tick();
        check("R13 one in flight", {31'b0, reg_rdata[31]}, 32'h0);
        txn_done = 1'b1;
        tick();
        txn_done = 1'b0;
        tick();
        check("R13 back to zero", {31'b0, reg_rdata[31]}, 32'h1);

        // R8: capability masks the interrupt enable
        cap_irq_support = 1'b0;
        #1;
        check("R8 bit reads 0", {31'b0, reg_rdata[8]}, 32'h0);
        unmapped_status = 1'b1;
        tick();
        tick();
        check("R8 no irq", {31'b0, unmapped_irq}, 32'h0);
        unmapped_status = 1'b0;
        cap_irq_support = 1'b1;

        // R11: reset mid-run restores reset state
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        check("R11 re-reset", reg_rdata, 32'h8000_0000);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule